// File: doc/BRIEF.md
# Page-Mode EEPROM Write Sequencer Model

This block is a synthesizable, clocked model of the device side of a page-mode EEPROM. It is meant to sit in an FPGA prototype or emulator where a real non-volatile part would be fitted. The block samples the active-low chip enable, output enable and write enable, the address, the write data and an active-low device reset on a fast system clock. It filters out short strobes and collects accepted bytes into a page buffer. Each byte in the buffer has its own valid flag. When the load window times out, the block programs only the loaded bytes into a backing array.

While a page is being loaded or programmed, the block raises a busy flag. A read in that period returns a polling status instead of array data. Holding the device reset low blocks all access. If the device reset goes low during programming, the operation is cut short and the loaded locations are left with a fixed corrupt value. Every time window is a clock-cycle parameter, so a simulation can run with short values. The backing array depth is set by the address width.

Top module: `eeprom_page_seq`

## Requirements
- R1: After the synchronous reset `rst_n` is released, `busy` and `rd_data_oe` are 0 and every array location reads 8'h00.
- R2: A cycle sampled with chip_en_n=0, out_en_n=0, wr_en_n=1 and dev_res_n=1 gives rd_data_oe=1 on the next cycle. While not busy, rd_data then holds the array byte at `addr`. In any other sampled combination, including chip_en_n=1, the next cycle shows rd_data_oe=0 and rd_data=8'h00.
- R3: A write strobe is counted only when chip_en_n=0, out_en_n=1, wr_en_n=0 and dev_res_n=1 hold for at least MIN_PULSE consecutive cycles. The byte is accepted in the first cycle after the strobe ends, and the address and data taken are those of the strobe's last cycle. A shorter strobe, or a strobe with out_en_n=0, has no effect.
- R4: `busy` is 1 from the cycle after the first accepted byte of a page until programming ends.
- R5: Each accepted byte restarts a load window of WIN_CYC cycles. The window also stays restarted while a strobe is being held. Programming then lasts PROG_CYC cycles. After the last accepted byte, `busy` falls WIN_CYC+PROG_CYC cycles after the cycle of acceptance.
- R6: At commit, only loaded offsets are written. Any other location keeps its previous value, and a later byte to the same offset replaces an earlier one.
- R7: The upper address bits (above the 7-bit page offset) are fixed by the first byte of a page. A later byte with different upper bits is ignored and does not restart the window.
- R8: A read while busy returns bit 7 equal to the complement of bit 7 of the last accepted byte, with bits 6:0 equal to 0.
- R9: While dev_res_n=0, reads give rd_data_oe=0 and strobes load nothing.
- R10: dev_res_n=0 during programming stops the operation, clears `busy` on the next cycle and writes 8'hFF to every loaded location. During loading it discards the buffer and leaves the array unchanged.
- R11: Strobes that arrive during programming are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole model |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| dev_res_n | input | 1 | Active-low device reset/protect input |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Data written by the host |
| rd_data | output | 8 | Read data, 8'h00 when not driven |
| rd_data_oe | output | 1 | High when rd_data would be driven onto the bus |
| busy | output | 1 | High while a page is loading or programming |

## Verification
All outputs are registered. A read sampled at one edge is visible on `rd_data`/`rd_data_oe` after that edge. A strobe counts only once its release has been sampled, and `busy` rises one edge after that release. Programming ends exactly WIN_CYC+PROG_CYC edges after acceptance. The bench drives inputs and samples outputs at falling edges, so each check lands on the first falling edge after the edge that produces the result. A behavioural model, kept with integers and arrays, predicts all three outputs for every cycle, and directed checks time the full busy interval edge by edge.

// File: rtl/eeprom_seq_pkg.sv
// Shared types for the page-mode EEPROM sequencer model.
package eeprom_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no page open
        ST_LOAD = 2'd1,   // collecting bytes, window running
        ST_PROG = 2'd2    // internal programming in progress
    } seq_state_t;
endpackage

// File: rtl/eps_strobe_filter.sv
// Write-strobe qualifier. Counts consecutive cycles of the write
// condition and flags acceptance in the first cycle after release
// when the run reached MIN_PULSE. Captures address and data each
// cycle the condition holds, so the last strobe cycle wins.
// Assumes the control inputs are already synchronous to clk.
module eps_strobe_filter #(
    parameter int MIN_PULSE = 5,
    parameter int ADDR_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cond,
    input  logic              res_ok,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              accept,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [7:0]        cap_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

    logic [CNT_W-1:0] run_cnt;

    // Saturating run-length counter of the write condition.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (wr_cond)
            run_cnt <= (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
        else
            run_cnt <= '0;
    end

    // Capture of address and data while the strobe is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (wr_cond) begin
            cap_addr <= addr_in;
            cap_data <= data_in;
        end
    end

    assign accept = !wr_cond && res_ok && (run_cnt == CNT_MAX);
endmodule

// File: rtl/eps_page_buffer.sv
// Page buffer: one data byte and one valid flag per page offset.
// A load writes one offset; clear drops all valid flags.
// Assumes clear and load are never requested in the same cycle
// for a useful result (clear wins).
module eps_page_buffer #(
    parameter int PAGE_BYTES = 128,
    parameter int PG_W       = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       load,
    input  logic [PG_W-1:0]            load_off,
    input  logic [7:0]                 load_data,
    output logic [PAGE_BYTES-1:0][7:0] buf_data,
    output logic [PAGE_BYTES-1:0]      buf_valid
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Per-offset storage and valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_data[g]  <= '0;
                buf_valid[g] <= 1'b0;
            end else if (clear) begin
                buf_valid[g] <= 1'b0;
            end else if (load && (load_off == PG_W'(g))) begin
                buf_data[g]  <= load_data;
                buf_valid[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/eps_ctrl.sv
// Sequencer control: idle, page load with restartable window,
// timed programming. Produces take/commit/abort strobes.
// Assumes WIN_CYC and PROG_CYC are at least 1.
module eps_ctrl
    import eeprom_seq_pkg::*;
#(
    parameter int WIN_CYC  = 20000,
    parameter int PROG_CYC = 2000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       res_ok,
    input  logic       wr_cond,
    input  logic       accept,
    input  logic       same_page,
    output seq_state_t state,
    output logic       take,
    output logic       commit,
    output logic       abort_fill
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);

    logic [WIN_W-1:0] win_cnt;
    logic [PRG_W-1:0] prg_cnt;

    // Byte acceptance, commit and abort decisions.
    always_comb begin
        take       = accept && ((state == ST_IDLE) ||
                                ((state == ST_LOAD) && same_page));
        commit     = res_ok && (state == ST_PROG) && (prg_cnt == PRG_LAST);
        abort_fill = !res_ok && (state == ST_PROG);
    end

    // State register with load-window and programming timers.
    always_ff @(posedge clk) begin
        if (!rst_n || !res_ok) begin
            state   <= ST_IDLE;
            win_cnt <= '0;
            prg_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        state   <= ST_LOAD;
                        win_cnt <= '0;
                    end
                end
                ST_LOAD: begin
                    if (take || wr_cond) begin
                        win_cnt <= '0;
                    end else if (win_cnt == WIN_LAST) begin
                        state   <= ST_PROG;
                        prg_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prg_cnt == PRG_LAST)
                        state <= ST_IDLE;
                    else
                        prg_cnt <= prg_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_page_seq.sv
// Top of the page-mode EEPROM write sequencer model. Decodes bus
// mode, qualifies strobes, buffers a page, commits loaded bytes to
// a flop-based backing array, and serves reads or polling status.
// Assumes ADDR_W > 7 (page offset width) and synchronous inputs.
module eeprom_page_seq
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MIN_PULSE = 5,
    parameter int WIN_CYC   = 20000,
    parameter int PROG_CYC  = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic              dev_res_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              rd_data_oe,
    output logic              busy
);
    localparam int PAGE_BYTES = 128;
    localparam int PG_W       = $clog2(PAGE_BYTES);
    localparam int HI_W       = ADDR_W - PG_W;
    localparam int MEM_DEPTH  = 1 << ADDR_W;

    logic                       wr_cond, rd_cond, res_ok;
    logic                       accept, take, commit, abort_fill, same_page;
    logic [ADDR_W-1:0]          cap_addr;
    logic [7:0]                 cap_data;
    logic [HI_W-1:0]            page_base;
    logic                       last_b7;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_valid;
    logic [7:0]                 mem [MEM_DEPTH];
    seq_state_t                 state;

    // Bus mode decode.
    always_comb begin
        res_ok    = dev_res_n;
        wr_cond   = !chip_en_n && out_en_n && !wr_en_n && res_ok;
        rd_cond   = !chip_en_n && !out_en_n && wr_en_n && res_ok;
        same_page = (cap_addr[ADDR_W-1:PG_W] == page_base);
    end

    eps_strobe_filter #(.MIN_PULSE(MIN_PULSE), .ADDR_W(ADDR_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .wr_cond(wr_cond), .res_ok(res_ok),
        .addr_in(addr), .data_in(wr_data), .accept(accept),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    eps_ctrl #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .res_ok(res_ok), .wr_cond(wr_cond),
        .accept(accept), .same_page(same_page), .state(state),
        .take(take), .commit(commit), .abort_fill(abort_fill)
    );

    eps_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(commit || !res_ok),
        .load(take), .load_off(cap_addr[PG_W-1:0]), .load_data(cap_data),
        .buf_data(buf_data), .buf_valid(buf_valid)
    );

    // Page address and polling bit, fixed by accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_base <= '0;
            last_b7   <= 1'b0;
        end else if (take) begin
            last_b7 <= cap_data[7];
            if (state == ST_IDLE)
                page_base <= cap_addr[ADDR_W-1:PG_W];
        end
    end

    // Backing array: commit loaded bytes, or poison them on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++)
                mem[i] <= 8'h00;
        end else begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (buf_valid[j]) begin
                    if (commit)
                        mem[{page_base, PG_W'(j)}] <= buf_data[j];
                    else if (abort_fill)
                        mem[{page_base, PG_W'(j)}] <= 8'hFF;
                end
            end
        end
    end

    // Registered read path with polling status while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= 8'h00;
            rd_data_oe <= 1'b0;
        end else begin
            rd_data_oe <= rd_cond;
            if (!rd_cond)
                rd_data <= 8'h00;
            else if (state != ST_IDLE)
                rd_data <= {~last_b7, 7'b0};
            else
                rd_data <= mem[addr];
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/eeprom_page_seq_chk.sv
// Temporal checks on the sequencer, bound into the top module.
module eeprom_page_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en_n,
    input logic       dev_res_n,
    input logic       rd_cond,
    input logic       take,
    input logic       busy,
    input logic       rd_data_oe,
    input logic [7:0] rd_data
);
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |=> !rd_data_oe); // R2
    AST_BUSY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy); // R4
    AST_POLL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cond && busy) |=> (rd_data_oe && rd_data[6:0] == 7'b0)); // R8
    AST_RES_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_res_n |=> !rd_data_oe); // R9
    AST_RES_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_res_n |=> !busy); // R10
endmodule

bind eeprom_page_seq eeprom_page_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .dev_res_n(dev_res_n),
    .rd_cond(rd_cond), .take(take), .busy(busy),
    .rd_data_oe(rd_data_oe), .rd_data(rd_data)
);

// File: tb/tb_eeprom_page_seq.sv
module tb_eeprom_page_seq;
    localparam int AW = 10, MINP = 5, WIN = 40, PROG = 100;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, oe_n = 1, we_n = 1, res_n = 1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] rd_data;
    logic rd_data_oe, busy;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    eeprom_page_seq #(.ADDR_W(AW), .MIN_PULSE(MINP), .WIN_CYC(WIN), .PROG_CYC(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .out_en_n(oe_n), .wr_en_n(we_n),
        .dev_res_n(res_n), .addr(addr), .wr_data(din),
        .rd_data(rd_data), .rd_data_oe(rd_data_oe), .busy(busy));

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_capa, m_state, m_win, m_pt, m_base;
    logic [7:0] m_capd, m_last;
    logic [7:0] m_mem [1 << AW];
    logic [7:0] m_buf [128];
    bit m_val [128];
    logic [7:0] e_dout;
    logic e_oe;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_capa = 0; m_capd = 0; m_state = 0; m_win = 0; m_pt = 0;
            m_base = 0; m_last = 0; e_dout = 0; e_oe = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
            foreach (m_val[i]) begin m_val[i] = 0; m_buf[i] = 0; end
        end else begin
            bit wr, rd, acc, tk, cm, ab;
            int st0;
            st0 = m_state;
            wr  = !ce_n && oe_n && !we_n && res_n;
            rd  = !ce_n && !oe_n && we_n && res_n;
            acc = !wr && (m_cnt >= MINP) && res_n;
            e_oe = rd;
            e_dout = !rd ? 8'h00 : (st0 != 0 ? {~m_last[7], 7'b0} : m_mem[addr]);
            tk = acc && (st0 == 0 || (st0 == 1 && (m_capa / 128) == m_base));
            cm = res_n && st0 == 2 && m_pt == PROG - 1;
            ab = !res_n && st0 == 2;
            for (int j = 0; j < 128; j++)
                if (m_val[j]) begin
                    if (cm) m_mem[m_base * 128 + j] = m_buf[j];
                    else if (ab) m_mem[m_base * 128 + j] = 8'hFF;
                end
            if (cm || !res_n) begin
                foreach (m_val[i]) m_val[i] = 0;
            end else if (tk) begin
                m_val[m_capa % 128] = 1;
                m_buf[m_capa % 128] = m_capd;
            end
            if (tk) begin
                m_last = m_capd;
                if (st0 == 0) m_base = m_capa / 128;
            end
            if (!res_n) begin
                m_state = 0; m_win = 0; m_pt = 0;
            end else if (st0 == 0) begin
                if (tk) begin m_state = 1; m_win = 0; end
            end else if (st0 == 1) begin
                if (tk || wr) m_win = 0;
                else if (m_win == WIN - 1) begin m_state = 2; m_pt = 0; end
                else m_win++;
            end else begin
                if (m_pt == PROG - 1) m_state = 0;
                else m_pt++;
            end
            if (wr) begin
                m_cnt = (m_cnt < MINP) ? m_cnt + 1 : MINP;
                m_capa = int'(addr); m_capd = din;
            end else m_cnt = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) if (rst_n) begin
        chk("R4 model busy", int'(busy), int'(m_state != 0));
        chk("R2 model oe", int'(rd_data_oe), int'(e_oe));
        chk("R8 model data", int'(rd_data), int'(e_dout));
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(int a, int d, int len);
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; addr = AW'(a); din = 8'(d);
        repeat (len - 1) @(negedge clk);
        @(negedge clk); ce_n = 1; we_n = 1;
    endtask

    task automatic rd(int a, output int d, output int o);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        @(negedge clk); d = int'(rd_data); o = int'(rd_data_oe); ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int d, o, n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 oe", int'(rd_data_oe), 0);
        rd(5, d, o); chk("R1 array", d, 0); chk("R2 oe on read", o, 1);

        // R2 standby
        @(negedge clk); ce_n = 1; oe_n = 0;
        @(negedge clk); chk("R2 standby oe", int'(rd_data_oe), 0); oe_n = 1;

        // Page with two bytes and a foreign-page byte (R4 R6 R7 R8)
        wr('h103, 'hA5, 6);
        @(negedge clk); chk("R4 busy after first byte", int'(busy), 1);
        wr('h107, 'h3C, 5);
        rd('h100, d, o); chk("R8 polling", d, 'h80);
        wr('h201, 'h77, 6);
        wait_idle();
        rd('h103, d, o); chk("R6 byte a", d, 'hA5);
        rd('h107, d, o); chk("R6 byte b", d, 'h3C);
        rd('h104, d, o); chk("R6 untouched", d, 0);
        rd('h201, d, o); chk("R7 foreign page", d, 0);

        // R3 short pulse and OE inhibit
        wr('h010, 'h11, MINP - 1);
        @(negedge clk); chk("R3 short pulse", int'(busy), 0);
        rd('h010, d, o); chk("R3 short pulse array", d, 0);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 'h011; din = 'h22;
        repeat (8) @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1;
        @(negedge clk); chk("R3 oe inhibit", int'(busy), 0);

        // R9 device reset blocks access
        res_n = 0;
        rd('h103, d, o); chk("R9 read blocked oe", o, 0); chk("R9 read data", d, 0);
        wr('h050, 'hAB, 6);
        res_n = 1;
        @(negedge clk); chk("R9 write blocked", int'(busy), 0);
        rd('h050, d, o); chk("R9 array", d, 0);

        // R5 timing and R6 overwrite
        wr('h103, 'h12, 6);
        wr('h103, 'h34, 6);
        n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 1000);
        chk("R5 busy span", n, WIN + PROG + 1);
        rd('h103, d, o); chk("R6 overwrite", d, 'h34);

        // R11 strobes during programming
        wr('h140, 'h21, 6);
        repeat (WIN + 5) @(negedge clk);
        wr('h145, 'h99, 6);
        wait_idle();
        rd('h145, d, o); chk("R11 ignored in prog", d, 0);
        rd('h140, d, o); chk("R11 page kept", d, 'h21);

        // R10 abort during programming
        wr('h182, 'h55, 6);
        repeat (WIN + 5) @(negedge clk);
        res_n = 0;
        @(negedge clk); chk("R10 abort clears busy", int'(busy), 0); res_n = 1;
        rd('h182, d, o); chk("R10 poisoned", d, 'hFF);
        rd('h183, d, o); chk("R10 unloaded kept", d, 0);

        // R10 abort during load
        wr('h300, 'h66, 6);
        @(negedge clk); res_n = 0;
        @(negedge clk); chk("R10 load abort busy", int'(busy), 0); res_n = 1;
        repeat (WIN + 5) @(negedge clk);
        chk("R10 no later prog", int'(busy), 0);
        rd('h300, d, o); chk("R10 load abort array", d, 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule